// File: doc/BRIEF.md
# Arbitrated Control/Status Register Cell

This block holds one control/status register of configurable width and reset value. Two writers can update it. The instruction-side port comes from the CSR execution unit. The core-side port comes from the logic around the register, for example a counter or a trap handler. When both write in the same cycle, the cell merges them bit by bit. A mask of protected bits and a priority parameter decide which writer each bit follows.

On the instruction side, a write takes effect only while a keep qualifier is high. This lets the surrounding unit filter or transform the data before it arrives. If the register's 12-bit address places it in the read-only space (upper two bits `2'b11`), every instruction write is dropped.

The cell has three read paths:
- the stored value on the instruction read port;
- a core-side peek of the stored value, plus two flags that show whether an instruction read or an instruction write reached the cell in this cycle;
- a combinational forward path that shows the in-flight instruction write data ahead of the clock edge.

Top module: `csr_cell`

## Requirements
- R1: While `rst` is high, the register loads the parameter `INIT_VAL` on each clock edge. It reads back as `INIT_VAL` after reset is released.
- R2: In a cycle with no write from either port, the stored value stays the same. Both `peek_rd_hit` and `peek_wr_hit` are low whenever `insn_rd_en` and `insn_wr_en` are low.
- R3: An applied instruction write with no core write updates the bits that are clear in `RO_MASK` to `insn_wr_data` on the next edge. Bits that are set in `RO_MASK` keep their value.
- R4: A core write with no instruction write loads all bits of `core_wr_data` on the next edge. `RO_MASK` does not apply to this port.
- R5: When an applied instruction write and a core write happen in the same cycle:
  - bits set in `RO_MASK` take `core_wr_data`;
  - with `INSN_WINS` = 1, the other bits take `insn_wr_data`;
  - with `INSN_WINS` = 0, the other bits take `core_wr_data`.
- R6: An instruction write with `insn_wr_keep` low changes no bit. A core write in the same cycle still applies.
- R7: When `CSR_ADDR[11:10]` is `2'b11`, no instruction write changes the register, whatever the state of `insn_wr_keep`.
- R8: `peek_rd_hit` equals `insn_rd_en` and `peek_wr_hit` equals `insn_wr_en` in the same cycle, combinationally.
- R9: `fwd_value` equals `insn_wr_data` whenever `insn_wr_en` is high, ignoring the mask, the keep qualifier, the address and the priority. Otherwise it equals the stored value.
- R10: `insn_rd_data` and `peek_value` both show the stored value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_rd_en | input | 1 | Instruction-side read strobe |
| insn_rd_data | output | WIDTH | Stored value for the instruction side |
| insn_wr_en | input | 1 | Instruction-side write strobe |
| insn_wr_keep | input | 1 | Qualifier: the instruction write is applied only when high |
| insn_wr_data | input | WIDTH | Instruction-side write data (already filtered/transformed) |
| core_wr_en | input | 1 | Core-side write strobe |
| core_wr_data | input | WIDTH | Core-side write data |
| peek_value | output | WIDTH | Stored value for core logic |
| peek_rd_hit | output | 1 | An instruction read reached the cell this cycle |
| peek_wr_hit | output | 1 | An instruction write reached the cell this cycle |
| fwd_value | output | WIDTH | In-flight instruction write data, else the stored value |

## Verification
The assertions rely on the following:
- strobes and data are stable around each rising edge;
- reset is asserted at time zero for at least one edge;
- the parameters are constant.

Under these assumptions, a cycle with no write, a dropped instruction write, or a write to a read-only address must leave the register unchanged. The bench drives inputs only on the falling edge and holds reset for several cycles at the start.

The bench runs three parameter sets side by side on shared stimulus. Together they cover both priority settings, a mixed protected-bit mask, and an address in the read-only space. Directed cycles hit every pairing of strobes and keep, and a random phase then mixes them freely.

// File: rtl/csr_cell_pkg.sv
package csr_cell_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_INSN = 2'd1,
        SRC_CORE = 2'd2,
        SRC_BOTH = 2'd3
    } wr_src_e;

    typedef struct packed {
        logic rd_hit;
        logic wr_hit;
    } access_t;

    function automatic logic addr_is_ro(input logic [11:0] addr);
        return addr[11:10] == 2'b11;
    endfunction

    function automatic wr_src_e pick_src(input logic insn_ok, input logic core_ok);
        case ({core_ok, insn_ok})
            2'b01:   return SRC_INSN;
            2'b10:   return SRC_CORE;
            2'b11:   return SRC_BOTH;
            default: return SRC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/csr_wr_merge.sv
module csr_wr_merge
    import csr_cell_pkg::*;
#(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] RO_MASK   = '0,
    parameter bit               INSN_WINS = 1'b1,
    parameter logic [11:0]      CSR_ADDR  = 12'h000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    input  logic             insn_wr_en,
    input  logic             insn_wr_keep,
    input  logic [WIDTH-1:0] insn_wr_data,
    input  logic             core_wr_en,
    input  logic [WIDTH-1:0] core_wr_data,
    output logic             we,
    output logic [WIDTH-1:0] d
);
    localparam bit               ADDR_RO = addr_is_ro(CSR_ADDR);
    localparam logic [WIDTH-1:0] WR_MASK = ~RO_MASK;

    logic    insn_ok;
    wr_src_e src;
    logic [WIDTH-1:0] both_val;

    assign insn_ok = insn_wr_en && insn_wr_keep && !ADDR_RO;
    assign src     = pick_src(insn_ok, core_wr_en);

    generate
        if (INSN_WINS) begin : g_insn_first
            assign both_val = (insn_wr_data & WR_MASK) | (core_wr_data & RO_MASK);
        end else begin : g_core_first
            assign both_val = core_wr_data;
        end
    endgenerate

    always_comb begin
        we = 1'b1;
        d  = cur;
        unique case (src)
            SRC_INSN: d = (cur & RO_MASK) | (insn_wr_data & WR_MASK);
            SRC_CORE: d = core_wr_data;
            SRC_BOTH: d = both_val;
            default:  we = 1'b0;
        endcase
    end

    // R6: dropped instruction write alone does not write
    a_r6_keep_drop: assert property (@(posedge clk) disable iff (rst)
        (insn_wr_en && !insn_wr_keep && !core_wr_en) |-> !we);

    // R3: lone instruction write leaves protected bits
    a_r3_ro_bits: assert property (@(posedge clk) disable iff (rst)
        (insn_wr_en && !core_wr_en && we) |-> (((d ^ cur) & RO_MASK) == '0));

    // R4: lone core write loads the full word
    a_r4_core_full: assert property (@(posedge clk) disable iff (rst)
        (core_wr_en && !insn_wr_en) |-> (we && d == core_wr_data));

    // R5: protected bits follow the core port in a merged write
    a_r5_merge_ro: assert property (@(posedge clk) disable iff (rst)
        (core_wr_en && insn_wr_en) |-> ((d & RO_MASK) == (core_wr_data & RO_MASK)));

    generate
        if (ADDR_RO) begin : g_ro_chk
            // R7: read-only address never lets an instruction write through
            a_r7_ro_addr: assert property (@(posedge clk) disable iff (rst)
                (!core_wr_en) |-> !we);
        end
    endgenerate

endmodule

// File: rtl/csr_store.sv
module csr_store #(
    parameter int               WIDTH    = 32,
    parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= INIT_VAL;
        else if (we)
            q <= d;
    end

    // R1: reset loads the initial value
    a_r1_init: assert property (@(posedge clk) rst |=> (q == INIT_VAL));

    // R2: no write enable keeps the value
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/csr_cell.sv
module csr_cell
    import csr_cell_pkg::*;
#(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] INIT_VAL  = '0,
    parameter logic [WIDTH-1:0] RO_MASK   = '0,
    parameter bit               INSN_WINS = 1'b1,
    parameter logic [11:0]      CSR_ADDR  = 12'h000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_rd_en,
    output logic [WIDTH-1:0] insn_rd_data,
    input  logic             insn_wr_en,
    input  logic             insn_wr_keep,
    input  logic [WIDTH-1:0] insn_wr_data,
    input  logic             core_wr_en,
    input  logic [WIDTH-1:0] core_wr_data,
    output logic [WIDTH-1:0] peek_value,
    output logic             peek_rd_hit,
    output logic             peek_wr_hit,
    output logic [WIDTH-1:0] fwd_value
);
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] d;
    logic             we;
    access_t          acc;

    csr_wr_merge #(
        .WIDTH(WIDTH), .RO_MASK(RO_MASK), .INSN_WINS(INSN_WINS), .CSR_ADDR(CSR_ADDR)
    ) u_merge (
        .clk(clk), .rst(rst), .cur(q),
        .insn_wr_en(insn_wr_en), .insn_wr_keep(insn_wr_keep), .insn_wr_data(insn_wr_data),
        .core_wr_en(core_wr_en), .core_wr_data(core_wr_data),
        .we(we), .d(d)
    );

    csr_store #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_store (
        .clk(clk), .rst(rst), .we(we), .d(d), .q(q)
    );

    assign acc.rd_hit = insn_rd_en;
    assign acc.wr_hit = insn_wr_en;

    assign insn_rd_data = q;
    assign peek_value   = q;
    assign peek_rd_hit  = acc.rd_hit;
    assign peek_wr_hit  = acc.wr_hit;
    assign fwd_value    = insn_wr_en ? insn_wr_data : q;

    // R9: without an instruction write the forward path shows the stored word
    always_comb begin
        if (!rst && !insn_wr_en)
            a_r9_fwd_idle: assert (fwd_value == peek_value);
    end

    // R2: idle cycle raises no access flag
    a_r2_flags_low: assert property (@(posedge clk) disable iff (rst)
        (!insn_rd_en && !insn_wr_en) |-> (!peek_rd_hit && !peek_wr_hit));

endmodule

// File: tb/sim_csr_cell.sv
module sim_csr_cell;
    localparam int          W    = 32;
    localparam logic [31:0] INIT = 32'h1234_5678;
    localparam logic [31:0] ROM  = 32'hFF00_00F0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          rd_en = 0, wr_en = 0, keep = 0, cw_en = 0;
    logic [W-1:0]  wr_d = '0, cw_d = '0;

    logic [W-1:0] rd_q [3];
    logic [W-1:0] pk_q [3];
    logic [W-1:0] fw_q [3];
    logic         rh_q [3];
    logic         wh_q [3];

    csr_cell #(.WIDTH(W), .INIT_VAL(INIT), .RO_MASK(ROM), .INSN_WINS(1'b1), .CSR_ADDR(12'h300)) u0 (
        .clk(clk), .rst(rst), .insn_rd_en(rd_en), .insn_rd_data(rd_q[0]),
        .insn_wr_en(wr_en), .insn_wr_keep(keep), .insn_wr_data(wr_d),
        .core_wr_en(cw_en), .core_wr_data(cw_d), .peek_value(pk_q[0]),
        .peek_rd_hit(rh_q[0]), .peek_wr_hit(wh_q[0]), .fwd_value(fw_q[0]));
    csr_cell #(.WIDTH(W), .INIT_VAL(INIT), .RO_MASK(ROM), .INSN_WINS(1'b0), .CSR_ADDR(12'h300)) u1 (
        .clk(clk), .rst(rst), .insn_rd_en(rd_en), .insn_rd_data(rd_q[1]),
        .insn_wr_en(wr_en), .insn_wr_keep(keep), .insn_wr_data(wr_d),
        .core_wr_en(cw_en), .core_wr_data(cw_d), .peek_value(pk_q[1]),
        .peek_rd_hit(rh_q[1]), .peek_wr_hit(wh_q[1]), .fwd_value(fw_q[1]));
    csr_cell #(.WIDTH(W), .INIT_VAL(INIT), .RO_MASK(ROM), .INSN_WINS(1'b1), .CSR_ADDR(12'hC00)) u2 (
        .clk(clk), .rst(rst), .insn_rd_en(rd_en), .insn_rd_data(rd_q[2]),
        .insn_wr_en(wr_en), .insn_wr_keep(keep), .insn_wr_data(wr_d),
        .core_wr_en(cw_en), .core_wr_data(cw_d), .peek_value(pk_q[2]),
        .peek_rd_hit(rh_q[2]), .peek_wr_hit(wh_q[2]), .fwd_value(fw_q[2]));

    // behavioural reference: one stored word per configuration
    logic [W-1:0] model [3];
    bit prio_m [3]   = '{1'b1, 1'b0, 1'b1};
    bit roaddr_m [3] = '{1'b0, 1'b0, 1'b1};

    function automatic logic [W-1:0] expect_next(input logic [W-1:0] cur, input bit prio, input bit roaddr);
        bit insn_take = wr_en && keep && !roaddr;
        logic [W-1:0] r = cur;
        if (insn_take && cw_en) begin
            for (int b = 0; b < W; b++)
                r[b] = (ROM[b] || !prio) ? cw_d[b] : wr_d[b];
        end else if (insn_take) begin
            for (int b = 0; b < W; b++)
                if (!ROM[b]) r[b] = wr_d[b];
        end else if (cw_en) begin
            r = cw_d;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++)
            model[i] <= rst ? INIT : expect_next(model[i], prio_m[i], roaddr_m[i]);
    end

    int compared = 0, mismatched = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input int inst, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s u%0d: actual %h expected %h", tag, what, inst, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < 3; i++) begin
            chk(tag, "stored/R10", i, rd_q[i], model[i]);
            chk(tag, "peek/R10", i, pk_q[i], model[i]);
            chk(tag, "fwd/R9", i, fw_q[i], wr_en ? wr_d : model[i]);
            chk(tag, "rdhit/R8", i, {31'd0, rh_q[i]}, {31'd0, rd_en});
            chk(tag, "wrhit/R8", i, {31'd0, wh_q[i]}, {31'd0, wr_en});
        end
    endtask

    task automatic step(input string tag, input bit r, input bit w, input bit k, input logic [W-1:0] wd,
                        input bit c, input logic [W-1:0] cd);
        @(negedge clk);
        rd_en = r; wr_en = w; keep = k; wr_d = wd; cw_en = c; cw_d = cd;
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step("R1", 0, 0, 0, '0, 0, '0);
        step("R2", 0, 0, 0, '0, 0, '0);
        step("R2", 0, 0, 1, 32'hFFFF_FFFF, 0, '0);
        step("R3", 1, 1, 1, 32'hAAAA_5555, 0, '0);
        step("R3", 0, 1, 1, 32'h0000_0000, 0, '0);
        step("R4", 0, 0, 0, '0, 1, 32'hDEAD_BEEF);
        step("R4", 0, 0, 0, '0, 1, 32'h0F0F_0F0F);
        step("R5", 0, 1, 1, 32'hFFFF_FFFF, 1, 32'h0000_0000);
        step("R5", 1, 1, 1, 32'h1357_9BDF, 1, 32'hF0E1_D2C3);
        step("R6", 0, 1, 0, 32'h7777_7777, 0, '0);
        step("R6", 0, 1, 0, 32'h8888_8888, 1, 32'h4242_4242);
        step("R7", 0, 1, 1, 32'h0BAD_F00D, 0, '0);
        step("R7", 0, 1, 0, 32'hCAFE_0000, 0, '0);
        step("R8", 1, 0, 0, '0, 0, '0);
        step("R9", 0, 1, 0, 32'h5A5A_A5A5, 0, '0);
        step("R2", 0, 0, 0, '0, 0, '0);
        for (int n = 0; n < 400; n++) begin
            logic [5:0] s = 6'($urandom);
            step("R5", s[0], s[1], s[2], $urandom, s[3], $urandom);
        end
        step("R2", 0, 0, 0, '0, 0, '0);
        @(negedge clk);
        rst = 1'b1;
        step("R1", 0, 0, 0, '0, 1, 32'h1111_1111);
        rst = 1'b0;
        step("R1", 0, 0, 0, '0, 0, '0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule